// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the processor status word of a 32-bit core and performs the bookkeeping for entering and leaving exceptions. Seven request lines are sampled when the core reports an instruction boundary. They are software reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction and software interrupt. The highest-priority unmasked request wins. For that request the block writes the return address and the pre-entry status into the banks of the target mode. It then switches mode, raises the interrupt-disable flags that the request calls for, drops back to the 4-byte instruction state and emits a load of the vector address.

A return strobe reloads the program counter from the current mode's link bank minus an offset that depends on the kind of exception that filled it. It restores the status word from the saved copy. The link value is corrected for the instruction state at entry. One handler return sequence therefore resumes correctly whether the interrupted code used 4-byte or 2-byte instructions.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the status word is 0x10 (user mode, both interrupt-disable flags clear, wide state) and `pc_load_o` is low. The link and saved-status outputs read 0 in user and system mode.
- R2: When several requests are valid together, the one taken is the first in this order: software reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R3: An entry takes effect at the first clock edge. In the next cycle `pc_load_o` is high and `pc_o` is the vector base plus the kind offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. The mode field `status_o[4:0]` takes the target encoding: user 10000, fast 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Reset, supervisor call and undefined go to supervisor and undefined mode respectively, and both aborts go to abort mode.
- R4: Apart from reset, an entry copies the current status into the target mode's saved status. That copy has `status_o[7]` as the interrupt-disable bit, `[6]` as the fast-interrupt-disable bit, `[5]` set from `narrow_i` and `[4:0]` as the mode.
- R5: Apart from reset, an entry writes the target mode's link bank with `cur_pc_i` plus an adjustment. The adjustment is +8 for data abort. For undefined and software interrupt it is +4 from wide state and +2 from compact state. It is +4 for the others.
- R6: Interrupt entry sets bit 7. Fast interrupt entry and software reset set bits 7 and 6. Other entries keep both bits. Every entry clears bit 5.
- R7: An interrupt request is ignored while bit 7 is set, and a fast interrupt request is ignored while bit 6 is set. A masked request does not block lower ones. No request is taken while `boundary_i` is low.
- R8: A return in an exception mode loads `pc_o` with the link bank minus 0 (undefined or software interrupt), 8 (data abort) or 4 (the others), raises `pc_load_o`, and restores the status word from the saved copy.
- R9: A return in user or system mode changes nothing and raises no load.
- R10: When an entry and a return occur in the same cycle, the entry is taken and the return is dropped.
- R11: In a cycle with neither entry nor return, bit 5 follows `narrow_i`, the rest of the status is kept and `pc_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary_i | input | 1 | Instruction boundary; requests sampled only here |
| req_rst_i | input | 1 | Software reset request |
| req_dabt_i | input | 1 | Data access fault |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Interrupt request |
| req_pabt_i | input | 1 | Instruction fetch fault |
| req_und_i | input | 1 | Undefined instruction |
| req_swi_i | input | 1 | Software interrupt |
| ret_i | input | 1 | Return-from-exception strobe |
| cur_pc_i | input | AW | Address of the instruction concerned |
| narrow_i | input | 1 | Current instruction state, 1 for 2-byte code |
| pc_load_o | output | 1 | Fetch redirect strobe |
| pc_o | output | AW | Redirect address |
| status_o | output | 8 | Status word: I, F, T, mode[4:0] |
| link_o | output | AW | Link bank of the current mode |
| spsr_o | output | 8 | Saved status of the current mode |

## Verification
Every result is registered, so the effect of inputs applied in one cycle appears in the cycle after the next rising edge. This covers the redirect strobe, its address, the new status and the banks now visible through `link_o` and `spsr_o`. The bench drives inputs just after an edge. It advances one edge and samples one time unit later, then compares all five outputs against a reference model stepped once for that same edge. The checker properties use a one-cycle `|=>` for the same reason.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam logic [4:0] MD_USR = 5'b10000;
   localparam logic [4:0] MD_FIQ = 5'b10001;
   localparam logic [4:0] MD_IRQ = 5'b10010;
   localparam logic [4:0] MD_SVC = 5'b10011;
   localparam logic [4:0] MD_ABT = 5'b10111;
   localparam logic [4:0] MD_UND = 5'b11011;
   localparam logic [4:0] MD_SYS = 5'b11111;

   // request kinds; value = priority index + 1, zero means none
   localparam int KW = 3;
   localparam logic [KW-1:0] K_NONE = 3'd0;
   localparam logic [KW-1:0] K_RST  = 3'd1;
   localparam logic [KW-1:0] K_DABT = 3'd2;
   localparam logic [KW-1:0] K_FIQ  = 3'd3;
   localparam logic [KW-1:0] K_IRQ  = 3'd4;
   localparam logic [KW-1:0] K_PABT = 3'd5;
   localparam logic [KW-1:0] K_UND  = 3'd6;
   localparam logic [KW-1:0] K_SWI  = 3'd7;

   localparam int NSRC  = 7;
   localparam int NBANK = 5;
   localparam int SW    = 8;

   typedef struct packed {
      logic       i_off;
      logic       f_off;
      logic       compact;
      logic [4:0] mode;
   } stat_t;

   function automatic logic [4:0] kind_mode(input logic [KW-1:0] k);
      case (k)
         K_FIQ:          return MD_FIQ;
         K_IRQ:          return MD_IRQ;
         K_DABT, K_PABT: return MD_ABT;
         K_UND:          return MD_UND;
         default:        return MD_SVC;
      endcase
   endfunction

   function automatic logic [4:0] kind_vec(input logic [KW-1:0] k);
      case (k)
         K_UND:   return 5'h04;
         K_SWI:   return 5'h08;
         K_PABT:  return 5'h0C;
         K_DABT:  return 5'h10;
         K_IRQ:   return 5'h18;
         K_FIQ:   return 5'h1C;
         default: return 5'h00;
      endcase
   endfunction

   function automatic logic [3:0] link_adj(input logic [KW-1:0] k, input logic compact);
      case (k)
         K_DABT:       return 4'd8;
         K_UND, K_SWI: return compact ? 4'd2 : 4'd4;
         default:      return 4'd4;
      endcase
   endfunction

   function automatic logic [3:0] ret_off(input logic [KW-1:0] k);
      case (k)
         K_DABT:       return 4'd8;
         K_UND, K_SWI: return 4'd0;
         default:      return 4'd4;
      endcase
   endfunction

   // {valid, slot}
   function automatic logic [3:0] mode_slot(input logic [4:0] m);
      case (m)
         MD_FIQ:  return 4'b1000;
         MD_IRQ:  return 4'b1001;
         MD_SVC:  return 4'b1010;
         MD_ABT:  return 4'b1011;
         MD_UND:  return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic          boundary_i,
   input  logic [N-1:0]  req_i,
   input  logic          irq_mask_i,
   input  logic          fiq_mask_i,
   output logic [KW-1:0] kind_o
);
   localparam int FIQ_BIT = int'(K_FIQ) - 1;
   localparam int IRQ_BIT = int'(K_IRQ) - 1;

   if (N != NSRC) begin : g_bad_n
      $error("trap_arbiter: N must equal the number of request kinds");
   end

   logic [N-1:0] mask_v;
   logic [N-1:0] live;

   always_comb begin
      mask_v          = '0;
      mask_v[FIQ_BIT] = fiq_mask_i;
      mask_v[IRQ_BIT] = irq_mask_i;
      live            = req_i & ~mask_v & {N{boundary_i}};
   end

   always_comb begin
      kind_o = K_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (live[i]) kind_o = KW'(i + 1);
      end
   end
endmodule

// File: rtl/trap_bank.sv
module trap_bank
   import trap_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [SW-1:0] spsr_i,
   input  logic [AW-1:0] link_i,
   input  logic [KW-1:0] kind_i,
   output logic [SW-1:0] spsr_o,
   output logic [AW-1:0] link_o,
   output logic [KW-1:0] kind_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spsr_o <= '0;
         link_o <= '0;
         kind_o <= K_NONE;
      end else if (we_i) begin
         spsr_o <= spsr_i;
         link_o <= link_i;
         kind_o <= kind_i;
      end
   end
endmodule

// File: rtl/trap_target.sv
module trap_target
   import trap_pkg::*;
#(
   parameter int              AW       = 32,
   parameter logic [AW-1:0]   VEC_BASE = '0
) (
   input  logic [KW-1:0] kind_i,
   input  logic [AW-1:0] pc_i,
   input  stat_t         cur_i,
   output logic [AW-1:0] vec_o,
   output stat_t         st_o,
   output logic [AW-1:0] link_o,
   output logic [2:0]    slot_o
);
   logic [3:0] slot_v;

   always_comb begin
      vec_o      = VEC_BASE + AW'(kind_vec(kind_i));
      link_o     = pc_i + AW'(link_adj(kind_i, cur_i.compact));
      st_o.mode  = kind_mode(kind_i);
      st_o.compact = 1'b0;
      st_o.i_off = cur_i.i_off | (kind_i == K_IRQ) | (kind_i == K_FIQ) | (kind_i == K_RST);
      st_o.f_off = cur_i.f_off | (kind_i == K_FIQ) | (kind_i == K_RST);
      slot_v     = mode_slot(st_o.mode);
      slot_o     = slot_v[2:0];
   end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          boundary_i,
   input  logic          req_rst_i,
   input  logic          req_dabt_i,
   input  logic          req_fiq_i,
   input  logic          req_irq_i,
   input  logic          req_pabt_i,
   input  logic          req_und_i,
   input  logic          req_swi_i,
   input  logic          ret_i,
   input  logic [AW-1:0] cur_pc_i,
   input  logic          narrow_i,
   output logic          pc_load_o,
   output logic [AW-1:0] pc_o,
   output logic [7:0]    status_o,
   output logic [AW-1:0] link_o,
   output logic [7:0]    spsr_o
);
   if (AW < 8) begin : g_bad_aw
      $error("trap_sequencer: AW must be at least 8");
   end
   if (VEC_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("trap_sequencer: VEC_BASE must be 32-byte aligned");
   end

   stat_t         st_q;
   stat_t         cur_st;
   stat_t         ent_st;
   logic [KW-1:0] kind;
   logic [AW-1:0] vec;
   logic [AW-1:0] ent_link;
   logic [2:0]    ent_slot;
   logic          take;
   logic [3:0]    here;
   logic          here_ok;
   logic          ret_ok;

   logic [SW-1:0] bk_spsr [NBANK];
   logic [AW-1:0] bk_link [NBANK];
   logic [KW-1:0] bk_kind [NBANK];
   logic [SW-1:0] sel_spsr;
   logic [AW-1:0] sel_link;
   logic [KW-1:0] sel_kind;

   always_comb begin
      cur_st         = st_q;
      cur_st.compact = narrow_i;
   end

   trap_arbiter #(.N(NSRC)) u_arb (
      .boundary_i (boundary_i),
      .req_i      ({req_swi_i, req_und_i, req_pabt_i, req_irq_i,
                    req_fiq_i, req_dabt_i, req_rst_i}),
      .irq_mask_i (st_q.i_off),
      .fiq_mask_i (st_q.f_off),
      .kind_o     (kind)
   );

   trap_target #(.AW(AW), .VEC_BASE(VEC_BASE)) u_tgt (
      .kind_i (kind),
      .pc_i   (cur_pc_i),
      .cur_i  (cur_st),
      .vec_o  (vec),
      .st_o   (ent_st),
      .link_o (ent_link),
      .slot_o (ent_slot)
   );

   assign take = (kind != K_NONE);

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic we;
      assign we = take && (kind != K_RST) && (ent_slot == 3'(g));
      trap_bank #(.AW(AW)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_i   (we),
         .spsr_i (cur_st),
         .link_i (ent_link),
         .kind_i (kind),
         .spsr_o (bk_spsr[g]),
         .link_o (bk_link[g]),
         .kind_o (bk_kind[g])
      );
   end

   always_comb begin
      here     = mode_slot(st_q.mode);
      here_ok  = here[3];
      sel_spsr = '0;
      sel_link = '0;
      sel_kind = K_NONE;
      for (int i = 0; i < NBANK; i++) begin
         if (here_ok && here[2:0] == 3'(i)) begin
            sel_spsr = bk_spsr[i];
            sel_link = bk_link[i];
            sel_kind = bk_kind[i];
         end
      end
      ret_ok = ret_i && !take && here_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= '{i_off: 1'b0, f_off: 1'b0, compact: 1'b0, mode: MD_USR};
         pc_o      <= '0;
         pc_load_o <= 1'b0;
      end else if (take) begin
         st_q      <= ent_st;
         pc_o      <= vec;
         pc_load_o <= 1'b1;
      end else if (ret_ok) begin
         st_q      <= stat_t'(sel_spsr);
         pc_o      <= sel_link - AW'(ret_off(sel_kind));
         pc_load_o <= 1'b1;
      end else begin
         st_q.compact <= narrow_i;
         pc_load_o    <= 1'b0;
      end
   end

   assign status_o = st_q;
   assign link_o   = sel_link;
   assign spsr_o   = sel_spsr;
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          boundary_i,
   input logic          req_rst_i,
   input logic          req_dabt_i,
   input logic          req_fiq_i,
   input logic          req_irq_i,
   input logic          req_pabt_i,
   input logic          req_und_i,
   input logic          req_swi_i,
   input logic          ret_i,
   input logic [AW-1:0] cur_pc_i,
   input logic          narrow_i,
   input logic          pc_load_o,
   input logic [AW-1:0] pc_o,
   input logic [7:0]    status_o,
   input logic [AW-1:0] link_o,
   input logic [7:0]    spsr_o
);
   logic any_req;
   logic user_like;
   assign any_req   = req_rst_i | req_dabt_i | req_fiq_i | req_irq_i |
                      req_pabt_i | req_und_i | req_swi_i;
   assign user_like = (status_o[4:0] == 5'b10000) || (status_o[4:0] == 5'b11111);

   p_rst_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && req_rst_i |=> pc_load_o && pc_o == VEC_BASE && status_o == 8'hD3);

   p_fiq_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && req_fiq_i && !status_o[6] && !req_rst_i && !req_dabt_i
      |=> status_o == 8'hD1 && pc_o == VEC_BASE + AW'(28));

   p_masked_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && req_irq_i && status_o[7] && !ret_i &&
      !(req_rst_i | req_dabt_i | req_fiq_i | req_pabt_i | req_und_i | req_swi_i)
      |=> !pc_load_o);

   p_no_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i && !ret_i |=> !pc_load_o);

   p_ret_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i && ret_i && user_like |=> !pc_load_o);

   p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i && ret_i && !user_like |=> pc_load_o && status_o == $past(spsr_o));

   p_swi_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && req_swi_i && !req_rst_i && !req_dabt_i && !req_pabt_i &&
      !req_und_i && !(req_irq_i && !status_o[7]) && !(req_fiq_i && !status_o[6])
      |=> link_o == $past(cur_pc_i) + ($past(narrow_i) ? AW'(2) : AW'(4)));

   p_entry_beats_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && ret_i && req_rst_i |=> status_o == 8'hD3);

   logic unused;
   assign unused = any_req;
endmodule

bind trap_sequencer trap_sequencer_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boundary_i (boundary_i),
   .req_rst_i  (req_rst_i),
   .req_dabt_i (req_dabt_i),
   .req_fiq_i  (req_fiq_i),
   .req_irq_i  (req_irq_i),
   .req_pabt_i (req_pabt_i),
   .req_und_i  (req_und_i),
   .req_swi_i  (req_swi_i),
   .ret_i      (ret_i),
   .cur_pc_i   (cur_pc_i),
   .narrow_i   (narrow_i),
   .pc_load_o  (pc_load_o),
   .pc_o       (pc_o),
   .status_o   (status_o),
   .link_o     (link_o),
   .spsr_o     (spsr_o)
);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary_i = 1'b0;
   logic        req_rst_i = 1'b0, req_dabt_i = 1'b0, req_fiq_i = 1'b0, req_irq_i = 1'b0;
   logic        req_pabt_i = 1'b0, req_und_i = 1'b0, req_swi_i = 1'b0;
   logic        ret_i = 1'b0;
   logic [31:0] cur_pc_i = '0;
   logic        narrow_i = 1'b0;
   logic        pc_load_o;
   logic [31:0] pc_o;
   logic [7:0]  status_o;
   logic [31:0] link_o;
   logic [7:0]  spsr_o;

   always #5 clk = ~clk;

   trap_sequencer u0 (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state; request index order: rst, dabt, fiq, irq, pabt, und, swi
   logic [7:0]  m_st = 8'h10;
   logic [31:0] m_pc = '0;
   logic        m_ld = 1'b0;
   logic [31:0] m_link [5];
   logic [7:0]  m_spsr [5];
   int          m_kind [5];

   function automatic int slot_of(input logic [4:0] m);
      case (m)
         5'b10001: return 0;
         5'b10010: return 1;
         5'b10011: return 2;
         5'b10111: return 3;
         5'b11011: return 4;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [4:0] mode_of(input int k);
      case (k)
         1, 4:    return 5'b10111;
         2:       return 5'b10001;
         3:       return 5'b10010;
         5:       return 5'b11011;
         default: return 5'b10011;
      endcase
   endfunction

   function automatic logic [31:0] vec_of(input int k);
      case (k)
         1: return 32'h10;
         2: return 32'h1C;
         3: return 32'h18;
         4: return 32'h0C;
         5: return 32'h04;
         6: return 32'h08;
         default: return 32'h00;
      endcase
   endfunction

   function automatic logic [31:0] adj_of(input int k, input bit nw);
      if (k == 1) return 32'd8;
      if (k == 5 || k == 6) return nw ? 32'd2 : 32'd4;
      return 32'd4;
   endfunction

   function automatic logic [31:0] back_of(input int k);
      if (k == 1) return 32'd8;
      if (k == 5 || k == 6) return 32'd0;
      return 32'd4;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit b, input bit [6:0] rq, input bit rt,
                       input logic [31:0] pc, input bit nw, input string tag);
      int k;
      int s;
      string t;
      logic [7:0] cur;
      boundary_i = b;
      {req_swi_i, req_und_i, req_pabt_i, req_irq_i, req_fiq_i, req_dabt_i, req_rst_i} = rq;
      ret_i = rt; cur_pc_i = pc; narrow_i = nw;
      cur = {m_st[7:6], nw, m_st[4:0]};
      k = -1;
      for (int i = 6; i >= 0; i--) begin
         if (b && rq[i] && !(i == 2 && m_st[6]) && !(i == 3 && m_st[7])) k = i;
      end
      s = slot_of(m_st[4:0]);
      if (k >= 0) begin
         t = "R3";
         if (k == 0) begin
            m_st = 8'hD3;
         end else begin
            s = slot_of(mode_of(k));
            m_spsr[s] = cur;
            m_link[s] = pc + adj_of(k, nw);
            m_kind[s] = k;
            m_st = {m_st[7] | (k == 2) | (k == 3), m_st[6] | (k == 2), 1'b0, mode_of(k)};
         end
         m_pc = vec_of(k);
         m_ld = 1'b1;
      end else if (rt && s >= 0) begin
         t = "R8";
         m_pc = m_link[s] - back_of(m_kind[s]);
         m_st = m_spsr[s];
         m_ld = 1'b1;
      end else begin
         t = "R11";
         m_st[5] = nw;
         m_ld = 1'b0;
      end
      if (tag != "") t = tag;
      @(posedge clk);
      #1;
      s = slot_of(m_st[4:0]);
      chk(t, "pc_load", 32'(pc_load_o), 32'(m_ld));
      chk(t, "pc", pc_o, m_pc);
      chk(t, "status", 32'(status_o), 32'(m_st));
      chk(t, "link", link_o, (s >= 0) ? m_link[s] : 32'd0);
      chk(t, "spsr", 32'(spsr_o), (s >= 0) ? 32'(m_spsr[s]) : 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 5; i++) begin
         m_link[i] = '0; m_spsr[i] = '0; m_kind[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "status", 32'(status_o), 32'h10);
      chk("R1", "pc_load", 32'(pc_load_o), 32'd0);
      chk("R1", "link", link_o, 32'd0);
      step(1'b0, 7'b0, 1'b0, 32'h40, 1'b0, "R1");
      // R9 return from user ignored
      step(1'b0, 7'b0, 1'b1, 32'h40, 1'b0, "R9");
      // R7 no boundary: requests ignored
      step(1'b0, 7'b1111111, 1'b0, 32'h44, 1'b0, "R7");
      // R3 software interrupt from wide code, then R8 return
      step(1'b1, 7'b1000000, 1'b0, 32'h100, 1'b0, "R3");
      chk("R3", "vector", pc_o, 32'h08);
      chk("R5", "wide link", link_o, 32'h104);
      step(1'b0, 7'b0, 1'b1, 32'h8, 1'b0, "R8");
      chk("R8", "resume", pc_o, 32'h104);
      // R5 software interrupt from compact code
      step(1'b1, 7'b1000000, 1'b0, 32'h200, 1'b1, "R5");
      chk("R5", "compact link", link_o, 32'h202);
      chk("R4", "saved status", 32'(spsr_o), 32'h30);
      step(1'b0, 7'b0, 1'b1, 32'h8, 1'b0, "R8");
      chk("R8", "compact resume", pc_o, 32'h202);
      // R11 state flag follows
      step(1'b0, 7'b0, 1'b0, 32'h204, 1'b0, "R11");
      // R2 data abort beats interrupt
      step(1'b1, 7'b0001010, 1'b0, 32'h300, 1'b0, "R2");
      chk("R2", "mode", 32'(status_o[4:0]), 32'h17);
      step(1'b0, 7'b0, 1'b1, 32'h0, 1'b0, "R8");
      // R6 interrupt entry, then R7 masked interrupt, R4 nested fast interrupt
      step(1'b1, 7'b0001000, 1'b0, 32'h400, 1'b0, "R6");
      step(1'b1, 7'b0001000, 1'b0, 32'h500, 1'b0, "R7");
      step(1'b1, 7'b0001100, 1'b0, 32'h504, 1'b1, "R4");
      chk("R6", "fiq flags", 32'(status_o), 32'hD1);
      step(1'b1, 7'b0000100, 1'b0, 32'h508, 1'b0, "R7");
      step(1'b0, 7'b0, 1'b1, 32'h0, 1'b0, "R8");
      step(1'b0, 7'b0, 1'b1, 32'h0, 1'b0, "R8");
      // R10 entry wins over return
      step(1'b1, 7'b0010000, 1'b1, 32'h600, 1'b0, "R10");
      step(1'b1, 7'b0000001, 1'b1, 32'h604, 1'b0, "R10");
      step(1'b0, 7'b0, 1'b1, 32'h0, 1'b0, "R8");
      // random mix
      for (int n = 0; n < 3000; n++) begin
         bit [6:0] rq;
         for (int j = 0; j < 7; j++) rq[j] = ($urandom % 10) == 0;
         if (($urandom % 4) != 0) rq[0] = 1'b0;
         step(($urandom % 4) != 0, rq, ($urandom % 4) == 0,
              $urandom & 32'hFFFF_FFFE, $urandom % 2, "");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule